// File: doc/BRIEF.md
# Prescaled Reload Event Counter

This block counts down on a slow, fixed-rate step that is derived from the system clock. Each step lowers a 32-bit down-count by one. When the down-count has already reached zero, the next step reloads it from a programmable reload register and adds one to a 32-bit event count. The block is a general-purpose timebase: software programs a reload value and reads the event count to learn how many full reload periods have passed.

A divider turns the system clock into a one-cycle step enable. The divider runs at the ratio `CLK_HZ / PRESCALE_HZ`, and the default step rate is 20 MHz. Software can write the reload register, the down-count and the event count directly through three separate load ports. It reads all three on plain outputs.

Top module: `psc_event_counter`

## Requirements
- R1: On a step, a non-zero down-count becomes its old value minus one, and the event count does not change.
- R2: On a step with the down-count at zero, the down-count takes the reload value held before that clock edge, and the event count increases by one on the same edge.
- R3: With a reload value of 5 and a starting down-count of 7, successive steps give 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5. The event count rises by one at the first return to 5 and again at the second.
- R4: With a reload value of 0, the down-count stays at 0 once it gets there, and the event count increases by one on every step.
- R5: A load strobe writes its register on the next clock edge. It leaves the other two registers unchanged. Without a step or a load strobe, all three registers hold their values.
- R6: `tick` is high for exactly one clock cycle in every `CLK_HZ/PRESCALE_HZ` cycles (10 with the defaults). When that ratio is 1, `tick` is constantly high.
- R7: Reset clears the reload register, the down-count and the event count to zero, and it restarts the step divider.
- R8: The event count wraps from 0xFFFFFFFF to 0.
- R9: A load to the down-count or the event count in the same cycle as a step wins for that register. The step still updates the register that was not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_we | input | 1 | Load strobe for the reload register |
| reload_wdata | input | 32 | Value for the reload register |
| down_we | input | 1 | Load strobe for the down-count |
| down_wdata | input | 32 | Value for the down-count |
| evt_we | input | 1 | Load strobe for the event count |
| evt_wdata | input | 32 | Value for the event count |
| tick | output | 1 | One-cycle step enable from the divider |
| reload_q | output | 32 | Current reload value |
| down_q | output | 32 | Current down-count |
| evt_q | output | 32 | Current event count |

## Verification
On every cycle, the assertions check the single-step rules: the decrement, the reload on a zero count, the event increment tied to that reload, the hold of each register when neither a step nor a load strobe is present, and the one-cycle width of the step. Only the bench's scenarios can show the behaviour that builds up over many steps. That covers the full example sequence with its two event increments, the reload-zero stick, the wrap of the event count and the spacing between steps. It also covers the outcome when a load and a step arrive in the same cycle.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int CNT_W = 32;
  typedef logic [CNT_W-1:0] cnt_t;

  // Next down-count for one step: decrement, or reload once zero
  function automatic cnt_t down_step(input cnt_t cur, input cnt_t reload);
    return (cur == '0) ? reload : cur - cnt_t'(1);
  endfunction

  // Event count after one reload event (modulo 2^CNT_W)
  function automatic cnt_t evt_step(input cnt_t cur);
    return cur + cnt_t'(1);
  endfunction
endpackage

// File: rtl/psc_tick_gen.sv
module psc_tick_gen #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int PRESCALE_HZ = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int RATIO = (CLK_HZ / PRESCALE_HZ < 1) ? 1 : CLK_HZ / PRESCALE_HZ;

  generate
    if (RATIO == 1) begin : g_const
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(RATIO);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(RATIO - 1);
      logic [DIV_W-1:0] div_cnt;
      logic             wrap_now;

      assign wrap_now = (div_cnt == LAST);
      assign tick     = wrap_now;

      always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (wrap_now) div_cnt <= '0;
        else               div_cnt <= div_cnt + DIV_W'(1);
      end

      AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
      AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= LAST); // R6
    end
  endgenerate
endmodule

// File: rtl/psc_down_stage.sv
module psc_down_stage
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load_we,
  input  cnt_t load_val,
  input  cnt_t reload,
  output cnt_t count,
  output logic reload_evt
);
  logic at_zero;

  assign at_zero    = (count == '0);
  assign reload_evt = tick && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load_we) count <= load_val;
    else if (tick)    count <= down_step(count, reload);
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_we && !at_zero) |=> (count == $past(count) - cnt_t'(1))); // R1
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && !load_we) |=> (count == $past(reload))); // R2
  AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_we) |=> $stable(count)); // R5
  AST_DOWN_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count == $past(load_val))); // R9
endmodule

// File: rtl/psc_event_acc.sv
module psc_event_acc
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic load_we,
  input  cnt_t load_val,
  output cnt_t count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load_we) count <= load_val;
    else if (inc)     count <= evt_step(count);
  end

  AST_EVT_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_we) |=> (count == $past(count) + cnt_t'(1))); // R2
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load_we) |=> $stable(count)); // R5
  AST_EVT_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count == $past(load_val))); // R9
endmodule

// File: rtl/psc_event_counter.sv
module psc_event_counter
  import psc_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int PRESCALE_HZ = 20_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_we,
  input  logic [CNT_W-1:0] reload_wdata,
  input  logic             down_we,
  input  logic [CNT_W-1:0] down_wdata,
  input  logic             evt_we,
  input  logic [CNT_W-1:0] evt_wdata,
  output logic             tick,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] down_q,
  output logic [CNT_W-1:0] evt_q
);
  cnt_t reload_r;
  logic reload_evt;

  psc_tick_gen #(.CLK_HZ(CLK_HZ), .PRESCALE_HZ(PRESCALE_HZ)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         reload_r <= '0;
    else if (reload_we) reload_r <= reload_wdata;
  end

  psc_down_stage u_down (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load_we   (down_we),
    .load_val  (down_wdata),
    .reload    (reload_r),
    .count     (down_q),
    .reload_evt(reload_evt)
  );

  psc_event_acc u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (reload_evt),
    .load_we (evt_we),
    .load_val(evt_wdata),
    .count   (evt_q)
  );

  assign reload_q = reload_r;

  AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_we |=> $stable(reload_q)); // R5
  AST_STICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down_q == '0 && reload_q == '0 && !down_we) |=> (down_q == '0)); // R4
endmodule

// File: tb/test_psc_event_counter.sv
`timescale 1ns/1ps
module test_psc_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reload_we = 1'b0, down_we = 1'b0, evt_we = 1'b0;
  logic [31:0] reload_wdata = '0, down_wdata = '0, evt_wdata = '0;
  logic        tick;
  logic [31:0] reload_q, down_q, evt_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psc_event_counter i_psc_event_counter (
    .clk(clk), .rst_n(rst_n),
    .reload_we(reload_we), .reload_wdata(reload_wdata),
    .down_we(down_we), .down_wdata(down_wdata),
    .evt_we(evt_we), .evt_wdata(evt_wdata),
    .tick(tick), .reload_q(reload_q), .down_q(down_q), .evt_q(evt_q)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Wait for a negedge where tick is high (the next posedge applies a step)
  task automatic wait_tick_neg();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  task automatic next_tick();
    wait_tick_neg();
    @(negedge clk);
  endtask

  task automatic wr_reload(input logic [31:0] v);
    reload_we = 1'b1; reload_wdata = v; @(negedge clk); reload_we = 1'b0;
  endtask
  task automatic wr_down(input logic [31:0] v);
    down_we = 1'b1; down_wdata = v; @(negedge clk); down_we = 1'b0;
  endtask
  task automatic wr_evt(input logic [31:0] v);
    evt_we = 1'b1; evt_wdata = v; @(negedge clk); evt_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R7", "reload after reset", reload_q, 32'd0);
    check("R7", "down after reset", down_q, 32'd0);
    check("R7", "event after reset", evt_q, 32'd0);
  endtask

  task automatic t_write_isolation();
    logic [31:0] e0;
    next_tick();
    e0 = evt_q;
    wr_reload(32'd5);
    check("R5", "down kept on reload write", down_q, 32'd0);
    check("R5", "event kept on reload write", evt_q, e0);
    wr_down(32'd7);
    check("R5", "reload kept on down write", reload_q, 32'd5);
    check("R5", "event kept on down write", evt_q, e0);
    wr_evt(32'd0);
    check("R5", "down kept on event write", down_q, 32'd7);
    check("R5", "reload kept on event write", reload_q, 32'd5);
    check("R5", "event written", evt_q, 32'd0);
  endtask

  // Runs after t_write_isolation: reload 5, down 7, event 0
  task automatic t_sequence();
    logic [31:0] d = 32'd7, e = 32'd0;
    for (int i = 1; i <= 14; i++) begin
      if (d != 0) d = d - 1; else begin e = e + 1; d = 32'd5; end
      next_tick();
      check((d == 5 && i > 2) ? "R2" : "R1", "down in sequence", down_q, d);
      check("R3", "event in sequence", evt_q, e);
    end
    check("R3", "final down", down_q, 32'd5);
    check("R3", "final event count", evt_q, 32'd2);
  endtask

  task automatic t_reload_zero();
    next_tick();
    wr_reload(32'd0);
    wr_down(32'd2);
    wr_evt(32'd100);
    next_tick(); check("R4", "down 2->1", down_q, 32'd1);
    next_tick(); check("R4", "down 1->0", down_q, 32'd0);
    check("R4", "no event before zero", evt_q, 32'd100);
    for (int i = 1; i <= 4; i++) begin
      next_tick();
      check("R4", "down sticks at zero", down_q, 32'd0);
      check("R4", "event every tick", evt_q, 32'd100 + i);
    end
  endtask

  task automatic t_wrap();
    next_tick();
    wr_reload(32'd3);
    wr_down(32'd0);
    wr_evt(32'hFFFF_FFFF);
    next_tick();
    check("R8", "event wraps", evt_q, 32'd0);
    check("R2", "reload after wrap", down_q, 32'd3);
  endtask

  task automatic t_collision();
    next_tick();
    wr_reload(32'd6);
    wr_down(32'd0);
    wr_evt(32'd40);
    wait_tick_neg();
    evt_we = 1'b1; evt_wdata = 32'h1234;
    @(negedge clk); evt_we = 1'b0;
    check("R9", "event load wins over step", evt_q, 32'h1234);
    check("R9", "down still reloads", down_q, 32'd6);
    wait_tick_neg();
    down_we = 1'b1; down_wdata = 32'd9;
    @(negedge clk); down_we = 1'b0;
    check("R9", "down load wins over step", down_q, 32'd9);
    check("R9", "event unchanged, down was non-zero", evt_q, 32'h1234);
  endtask

  task automatic t_rate();
    int gap = 0;
    wait_tick_neg();
    @(negedge clk);
    check("R6", "tick one cycle wide", {31'd0, tick}, 32'd0);
    gap = 1;
    while (!tick) begin @(negedge clk); gap++; end
    check("R6", "cycles between ticks", gap, 32'd10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_isolation();
    t_sequence();
    t_reload_zero();
    t_wrap();
    t_collision();
    t_rate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule